// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Arbiter

This block joins several interrupt-raising devices to a processor through one shared request line and one acknowledge line. Each device is modelled as a slice that holds a pending flag. The shared request line is the OR of all pending flags. When the processor raises its acknowledge, the acknowledge travels down the chain from slice 0. It passes unchanged through every slice that is not pending. The first pending slice it reaches keeps it and stops it from going further.

The winning slice puts its own vector on the shared vector bus. The processor uses that vector to find the handler for the device. Priority comes only from where a slice sits in the chain. When the processor drops the acknowledge, the winner's pending flag is cleared and the request line then shows only the slices still waiting. If no slice is pending when the acknowledge rises, the vector bus stays at zero and a flag at the far end of the chain says that no device answered.

The number of slices, the vector width and the table of per-slice vectors are parameters. The acknowledge is sampled once per clock. Its rising edge is the moment at which the chain decides the winner.

Top module: `irq_daisy_arbiter`

## Requirements
- R1: While reset is asserted, and at the first sampling point after it is released, irq_out, vec_out and no_responder are all 0.
- R2: A 1 on bit i of dev_req at a rising clock edge sets slice i pending. irq_out is 1 from the next cycle on, until that slice is serviced.
- R3: irq_out is 1 exactly when at least one slice is pending.
- R4: At the clock edge where ack_in is first seen high (it was low at the previous edge), the pending slice with the lowest index wins. Slice 0 sits nearest the processor. Higher-index pending slices do not win.
- R5: From the cycle after the winning edge until the edge where ack_in is first seen low, vec_out carries the winner's vector. At all other times vec_out is 0.
- R6: A slice that becomes pending while an acknowledge is already held does not take that acknowledge. vec_out does not change until the acknowledge falls.
- R7: At the edge where ack_in is first seen low, the winning slice's pending flag is cleared. The other pending flags are kept.
- R8: If no slice is pending at the winning edge, vec_out stays 0 and no_responder is 1 until the acknowledge falls, when no_responder returns to 0.
- R9: A new request on the winning slice at the same edge where its acknowledge falls leaves that slice pending.
- R10: Slice i's vector is bits [i*VEC_W +: VEC_W] of VECTOR_TABLE, so each slice returns its own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | NUM_SLICES | Per-slice request pulses; bit i sets slice i pending |
| ack_in | input | 1 | Acknowledge from the processor, entering slice 0 |
| irq_out | output | 1 | Shared request line to the processor |
| vec_out | output | VEC_W | Vector of the acknowledged slice, or zero |
| no_responder | output | 1 | Acknowledge reached the end of the chain with no taker |

## Verification
The bench builds the block with five slices of 8-bit vectors. Each slice gets a different vector, so a wrong winner always shows up as a different value on vec_out. Five slices give room for a pending slice at the head, in the middle and at the tail of the chain at the same time, so the ripple past non-pending slices is tested as well as capture at every position. Directed sequences cover a request that arrives while an acknowledge is held, a request on the winner at the same edge its acknowledge falls, and an acknowledge with nothing pending. A long random run then checks the block on every cycle against a behavioural model.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  // The acknowledge moves past a slice only if that slice is idle
  function automatic logic pass_on(input logic ack_here, input logic pending);
    return ack_here & ~pending;
  endfunction

  // A pending slice keeps the acknowledge that reaches it
  function automatic logic take_ack(input logic ack_here, input logic pending);
    return ack_here & pending;
  endfunction

  // Clearing is done before setting, so a new request is never lost
  function automatic logic next_pending(input logic pend, input logic won,
                                        input logic fall, input logic set);
    return (pend & ~(won & fall)) | set;
  endfunction

  // The winner is decided at the rising edge and held until the falling edge
  function automatic logic next_won(input logic won, input logic rise,
                                    input logic fall, input logic take);
    if (rise) return take;
    if (fall) return 1'b0;
    return won;
  endfunction

endpackage

// File: rtl/irq_ack_edge.sv
module irq_ack_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  output logic ack_rise,
  output logic ack_fall
);
  logic ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_in;
  end

  assign ack_rise = ack_in & ~ack_q;
  assign ack_fall = ~ack_in & ack_q;
endmodule

// File: rtl/irq_slice.sv
module irq_slice
  import irq_chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic ack_rise,
  input  logic ack_fall,
  input  logic chain_in,
  output logic chain_out,
  output logic pending,
  output logic won
);
  logic take;

  assign take      = take_ack(chain_in, pending);
  assign chain_out = pass_on(chain_in, pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      won     <= 1'b0;
    end else begin
      pending <= next_pending(pending, won, ack_fall, req_set);
      won     <= next_won(won, ack_rise, ack_fall, take);
    end
  end
endmodule

// File: rtl/irq_vec_combine.sv
module irq_vec_combine #(
  parameter int NUM_SLICES = 4,
  parameter int VEC_W      = 8,
  parameter logic [NUM_SLICES*VEC_W-1:0] VECTOR_TABLE = '0
) (
  input  logic [NUM_SLICES-1:0] won,
  output logic [VEC_W-1:0]      vec_out
);
  logic [NUM_SLICES-1:0][VEC_W-1:0] masked;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_mask
    assign masked[i] = won[i] ? VECTOR_TABLE[i*VEC_W +: VEC_W] : '0;
  end

  // One-hot OR: at most one slice is non-zero
  always_comb begin
    vec_out = '0;
    for (int i = 0; i < NUM_SLICES; i++) vec_out = vec_out | masked[i];
  end
endmodule

// File: rtl/irq_daisy_arbiter.sv
module irq_daisy_arbiter #(
  parameter int NUM_SLICES = 4,
  parameter int VEC_W      = 8,
  parameter logic [NUM_SLICES*VEC_W-1:0] VECTOR_TABLE = 32'h4C48_4440
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SLICES-1:0] dev_req,
  input  logic                  ack_in,
  output logic                  irq_out,
  output logic [VEC_W-1:0]      vec_out,
  output logic                  no_responder
);
  localparam int CHAIN_LEN = NUM_SLICES + 1;

  logic                  ack_rise;
  logic                  ack_fall;
  logic [CHAIN_LEN-1:0]  chain;
  logic [NUM_SLICES-1:0] slice_pend;
  logic [NUM_SLICES-1:0] slice_won;
  logic                  chain_end;

  irq_ack_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_in   (ack_in),
    .ack_rise (ack_rise),
    .ack_fall (ack_fall)
  );

  assign chain[0] = ack_in;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    irq_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_set   (dev_req[i]),
      .ack_rise  (ack_rise),
      .ack_fall  (ack_fall),
      .chain_in  (chain[i]),
      .chain_out (chain[i+1]),
      .pending   (slice_pend[i]),
      .won       (slice_won[i])
    );
  end

  assign chain_end = chain[CHAIN_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        no_responder <= 1'b0;
    else if (ack_rise) no_responder <= chain_end;
    else if (ack_fall) no_responder <= 1'b0;
  end

  // Stands in for the wired-OR request line
  assign irq_out = |slice_pend;

  irq_vec_combine #(
    .NUM_SLICES   (NUM_SLICES),
    .VEC_W        (VEC_W),
    .VECTOR_TABLE (VECTOR_TABLE)
  ) u_vec (
    .won     (slice_won),
    .vec_out (vec_out)
  );
endmodule

// File: rtl/irq_daisy_checker.sv
module irq_daisy_checker #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] dev_req,
  input logic         irq_out,
  input logic [W-1:0] vec_out,
  input logic         no_responder,
  input logic [N-1:0] won,
  input logic [N-1:0] pend,
  input logic         ack_rise,
  input logic         ack_fall
);
  AST_WON_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(won)); // R4

  AST_REQ_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_req) |=> irq_out); // R2

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !ack_fall) |=> irq_out); // R3

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (won == '0) |-> (vec_out == '0)); // R5

  AST_WON_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_rise && !ack_fall) |=> $stable(won)); // R6

  AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && (won != '0)) |=> ((pend & $past(won) & ~$past(dev_req)) == '0)); // R7

  AST_NORESP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    no_responder |-> (won == '0 && vec_out == '0)); // R8

  AST_REQ_ON_FALL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && ((won & dev_req) != '0)) |=> ((pend & $past(won)) != '0)); // R9
endmodule

bind irq_daisy_arbiter irq_daisy_checker #(.N(NUM_SLICES), .W(VEC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dev_req      (dev_req),
  .irq_out      (irq_out),
  .vec_out      (vec_out),
  .no_responder (no_responder),
  .won          (slice_won),
  .pend         (slice_pend),
  .ack_rise     (ack_rise),
  .ack_fall     (ack_fall)
);

// File: tb/tb_irq_daisy_arbiter.sv
module tb_irq_daisy_arbiter;
  localparam int N = 5;
  localparam int W = 8;

  function automatic logic [W-1:0] exp_vec(input int idx);
    return 8'h20 + 8'(idx * 8);
  endfunction

  function automatic logic [N*W-1:0] build_table();
    logic [N*W-1:0] t;
    t = '0;
    for (int i = 0; i < N; i++) t[i*W +: W] = exp_vec(i);
    return t;
  endfunction

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic         ack_in = 1'b0;
  logic         irq_out;
  logic [W-1:0] vec_out;
  logic         no_responder;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_daisy_arbiter #(
    .NUM_SLICES   (N),
    .VEC_W        (W),
    .VECTOR_TABLE (build_table())
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_req      (dev_req),
    .ack_in       (ack_in),
    .irq_out      (irq_out),
    .vec_out      (vec_out),
    .no_responder (no_responder)
  );

  // Behavioural reference model
  bit [N-1:0] m_pend;
  int         m_won;
  bit         m_nr;
  bit         m_ack_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_won = -1; m_nr = 1'b0; m_ack_prev = 1'b0;
    end else begin
      if (ack_in && !m_ack_prev) begin
        m_won = -1;
        for (int i = 0; i < N; i++) if (m_pend[i] && m_won < 0) m_won = i;
        m_nr = (m_won < 0);
      end else if (!ack_in && m_ack_prev) begin
        if (m_won >= 0) m_pend[m_won] = 1'b0;
        m_won = -1;
        m_nr = 1'b0;
      end
      m_pend = m_pend | dev_req;
      m_ack_prev = ack_in;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 irq_out", 32'(irq_out), 32'(m_pend != '0));
      check("R5 vec_out", 32'(vec_out), (m_won >= 0) ? 32'(exp_vec(m_won)) : 32'd0);
      check("R8 no_responder", 32'(no_responder), 32'(m_nr));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] r);
    dev_req = r;
    tick();
    dev_req = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", 32'(irq_out), 0);
    check("R1 vec in reset", 32'(vec_out), 0);
    rst_n = 1'b1;
    tick();
    check("R1 irq after reset", 32'(irq_out), 0);
    check("R1 noresp after reset", 32'(no_responder), 0);

    // R2: request on slice 2
    pulse(5'b00100);
    check("R2 irq raised", 32'(irq_out), 1);
    // R4, R5: acknowledge passes idle slices 0 and 1 and lands on slice 2
    ack_in = 1'b1;
    tick();
    check("R4 winner slice2", 32'(vec_out), 32'(exp_vec(2)));
    // R6: late request on slice 0 must not take the held acknowledge
    pulse(5'b00001);
    tick();
    check("R6 vec unchanged", 32'(vec_out), 32'(exp_vec(2)));
    ack_in = 1'b0;
    tick();
    check("R5 vec zero after fall", 32'(vec_out), 0);
    check("R7 slice0 still pending", 32'(irq_out), 1);
    ack_in = 1'b1;
    tick();
    check("R7 slice0 now wins", 32'(vec_out), 32'(exp_vec(0)));
    ack_in = 1'b0;
    tick();
    check("R7 all cleared", 32'(irq_out), 0);

    // R4, R10: slices 1, 3 and 4 pending, served in order
    pulse(5'b11010);
    for (int k = 0; k < 3; k++) begin
      ack_in = 1'b1;
      tick();
      check("R10 ordered vector", 32'(vec_out), 32'(exp_vec(k == 0 ? 1 : (k == 1 ? 3 : 4))));
      ack_in = 1'b0;
      tick();
    end
    check("R3 irq low when empty", 32'(irq_out), 0);

    // R8: acknowledge with nothing pending
    ack_in = 1'b1;
    tick();
    check("R8 noresp high", 32'(no_responder), 1);
    check("R8 vec zero", 32'(vec_out), 0);
    ack_in = 1'b0;
    tick();
    check("R8 noresp cleared", 32'(no_responder), 0);

    // R9: new request on winner at its falling edge
    pulse(5'b00010);
    ack_in = 1'b1;
    tick();
    check("R9 winner slice1", 32'(vec_out), 32'(exp_vec(1)));
    ack_in = 1'b0;
    dev_req = 5'b00010;
    tick();
    dev_req = '0;
    check("R9 slice1 kept pending", 32'(irq_out), 1);
    ack_in = 1'b1;
    tick();
    check("R9 slice1 wins again", 32'(vec_out), 32'(exp_vec(1)));
    ack_in = 1'b0;
    tick();

    // Random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      dev_req = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      if ($urandom_range(0, 4) == 0) ack_in = ~ack_in;
      tick();
    end
    dev_req = '0;
    ack_in = 1'b0;
    tick();
    finish_run();
  end
endmodule